// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block maintains the chain of extended capability headers stored in a 4 KB configuration space. The chain begins at byte offset 0x100. Each entry holds a single 32-bit header dword. That dword packs a capability identifier, a version nibble and the byte offset of the next entry. The walker reaches configuration storage through a simple dword port. A read returns its data one cycle after the request, and a write completes in a single cycle.

Two commands are supported:

- **Find** follows the chain and looks for a given identifier. It returns the offset of the matching entry and the offset of the entry visited just before it. Searching for identifier 0 stops at the last entry of the chain, because 0 is never matched by a real capability.
- **Append** places a new header at a caller-chosen offset. If that offset is the chain start, the header is written in place and keeps the link that was already stored there. Any other offset is linked behind the current last entry.

A corrupt chain ends the command with an error flag instead of hanging the walker. This covers a link that is misaligned, a link that points outside the legal window, and a chain that loops.

Top module: `extcap_walker`

## Requirements
- R1: Header dword layout is identifier in bits [15:0], version in bits [19:16] and next-entry byte offset in bits [31:20]. The chain starts at byte offset 0x100. Memory addresses are 12-bit byte offsets. Read data is valid in the cycle after `mem_rd_en`, and no cycle both reads and writes.
- R2: When the header dword at 0x100 is all zero, a find returns offset 0, previous 0 and no error.
- R3: A find whose identifier matches an entry returns that entry's offset together with the offset of the entry visited before it. The previous offset is 0 when the match is the entry at 0x100.
- R4: A find that reaches an entry with next offset 0 without a match returns offset 0, with previous equal to the last entry's offset. A find for identifier 0 therefore reports the chain tail as previous.
- R5: A next offset is followed only when it is dword aligned and lies in 0x100..0xFF8 inclusive. A bad pointer ends the command with `res_err`=1, offset 0 and previous 0, and every read stays inside that window.
- R6: A walk that would visit more than MAX_VISITS (default 1024) entries ends with `res_err`=1, so a looping chain cannot hang the block.
- R7: An append at offset 0x100 writes {old next field at 0x100, version, identifier} to 0x100. It returns offset 0x100 and previous 0.
- R8: An append elsewhere rewrites the tail header at the tail offset with the new offset in bits [31:20] and bits [19:0] unchanged. It then writes {0, version, identifier} at the new offset and returns the new offset and the tail offset as previous.
- R9: An append is rejected (`res_err`=1, no memory write) in any of these cases:
  - size below 8;
  - offset below 0x100;
  - offset plus size not below 0x1000;
  - offset not dword aligned;
  - offset not 0x100 while the chain is empty.
- R10: `cmd_append`=0 selects find and 1 selects append. Each accepted command produces exactly one `done` pulse of one cycle, with the results held afterwards. `busy` is high while a command is in progress, and `cmd_valid` is ignored while `busy` is high.
- R11: After reset `busy`, `done`, `res_err`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_append | input | 1 | 0 = find, 1 = append |
| cmd_id | input | 16 | Capability identifier |
| cmd_ver | input | 4 | Version for append |
| cmd_offset | input | 12 | Byte offset of the new entry for append |
| cmd_size | input | 13 | Byte size of the new entry for append |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_offset | output | 12 | Found or appended offset |
| res_prev | output | 12 | Previous entry offset |
| res_err | output | 1 | Command ended in error |
| mem_rd_en | output | 1 | Configuration read request |
| mem_wr_en | output | 1 | Configuration write request |
| mem_addr | output | 12 | Byte offset of the access |
| mem_wr_data | output | 32 | Write data |
| mem_rd_data | input | 32 | Read data, one cycle after request |

## Verification
The hardest situations to reach from the ports are a corrupt chain and the loop abort. Appends through the command interface can only ever build a well-formed chain. To reach these cases, the bench rewrites header dwords directly in the configuration memory model it owns. It plants a misaligned link, links just below and just above the legal window, a link to exactly 0xFF8, and a link that closes the chain back onto 0x100. It then issues a find for an absent identifier. In the loop case the walker has to circle the three-entry chain until the visit limit trips, which takes roughly two thousand cycles. A command strobed while a find is in flight checks that the strobe is dropped. The bench confirms this through the single completion and through memory left untouched at the would-be append target.

// File: rtl/extcap_pkg.sv
package extcap_pkg;
  localparam int PTR_W   = 12;
  localparam int ID_W    = 16;
  localparam int VER_W   = 4;
  localparam int SPACE_B = 1 << PTR_W;

  typedef struct packed {
    logic [PTR_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } ext_hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_CMP     = 3'd2,
    ST_WR_TAIL = 3'd3,
    ST_WR_NEW  = 3'd4
  } walk_state_e;
endpackage

// File: rtl/extcap_req_check.sv
module extcap_req_check
  import extcap_pkg::*;
#(
  parameter int BASE_OFF = 256
) (
  input  logic [PTR_W-1:0] offset,
  input  logic [PTR_W:0]   size,
  output logic             req_ok
);
  localparam int SUM_W = PTR_W + 2;
  logic [SUM_W-1:0] end_b;

  always_comb begin
    end_b  = SUM_W'(offset) + SUM_W'(size);
    req_ok = (size >= (PTR_W+1)'(8)) &&
             (offset >= PTR_W'(BASE_OFF)) &&
             (offset[1:0] == 2'b00) &&
             (end_b < SUM_W'(SPACE_B));
  end
endmodule

// File: rtl/extcap_ptr_check.sv
module extcap_ptr_check
  import extcap_pkg::*;
#(
  parameter int BASE_OFF = 256
) (
  input  logic [PTR_W-1:0] ptr,
  output logic             ptr_ok
);
  localparam int LAST_OFF = SPACE_B - 8;

  always_comb begin
    ptr_ok = (ptr[1:0] == 2'b00) &&
             (ptr >= PTR_W'(BASE_OFF)) &&
             ({1'b0, ptr} <= (PTR_W+1)'(LAST_OFF));
  end
endmodule

// File: rtl/extcap_visit_ctr.sv
module extcap_visit_ctr #(
  parameter int MAX_VISITS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_VISITS + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == CW'(MAX_VISITS - 1));
endmodule

// File: rtl/extcap_walker.sv
module extcap_walker
  import extcap_pkg::*;
#(
  parameter int BASE_OFF   = 256,
  parameter int MAX_VISITS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_append,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [VER_W-1:0]  cmd_ver,
  input  logic [PTR_W-1:0]  cmd_offset,
  input  logic [PTR_W:0]    cmd_size,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  res_offset,
  output logic [PTR_W-1:0]  res_prev,
  output logic              res_err,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [31:0]       mem_wr_data,
  input  logic [31:0]       mem_rd_data
);
  localparam logic [PTR_W-1:0] BASE = PTR_W'(BASE_OFF);

  walk_state_e      st_q, st_d;
  logic             app_q, app_d;
  logic [ID_W-1:0]  srch_q, srch_d, id_q, id_d;
  logic [VER_W-1:0] ver_q, ver_d;
  logic [PTR_W-1:0] off_q, off_d, cur_q, cur_d, prev_q, prev_d;
  ext_hdr_t         hdr_q, hdr_d, rd_hdr;
  logic [PTR_W-1:0] roff_q, roff_d, rprev_q, rprev_d;
  logic             err_q, err_d, done_q, done_d;
  logic             ctx_en, walk_en, res_en;
  logic             req_ok, ptr_ok, at_limit, cnt_clr, cnt_inc;

  assign rd_hdr = ext_hdr_t'(mem_rd_data);

  extcap_req_check #(.BASE_OFF(BASE_OFF)) u_req (
    .offset(cmd_offset), .size(cmd_size), .req_ok(req_ok)
  );

  extcap_ptr_check #(.BASE_OFF(BASE_OFF)) u_ptr (
    .ptr(rd_hdr.nxt), .ptr_ok(ptr_ok)
  );

  extcap_visit_ctr #(.MAX_VISITS(MAX_VISITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .at_limit(at_limit)
  );

  // next-state logic
  always_comb begin
    st_d        = st_q;
    app_d       = app_q;
    srch_d      = srch_q;
    id_d        = id_q;
    ver_d       = ver_q;
    off_d       = off_q;
    cur_d       = cur_q;
    prev_d      = prev_q;
    hdr_d       = hdr_q;
    roff_d      = roff_q;
    rprev_d     = rprev_q;
    err_d       = err_q;
    done_d      = 1'b0;
    ctx_en      = 1'b0;
    walk_en     = 1'b0;
    res_en      = 1'b0;
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    mem_rd_en   = 1'b0;
    mem_wr_en   = 1'b0;
    mem_addr    = cur_q;
    mem_wr_data = '0;

    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (cmd_append && !req_ok) begin
            res_en  = 1'b1;
            done_d  = 1'b1;
            err_d   = 1'b1;
            roff_d  = '0;
            rprev_d = '0;
          end else begin
            ctx_en  = 1'b1;
            walk_en = 1'b1;
            cnt_clr = 1'b1;
            app_d   = cmd_append;
            srch_d  = cmd_append ? '0 : cmd_id;
            id_d    = cmd_id;
            ver_d   = cmd_ver;
            off_d   = cmd_offset;
            cur_d   = BASE;
            prev_d  = '0;
            st_d    = ST_READ;
          end
        end
      end

      ST_READ: begin
        mem_rd_en = 1'b1;
        mem_addr  = cur_q;
        st_d      = ST_CMP;
      end

      ST_CMP: begin
        walk_en = 1'b1;
        hdr_d   = rd_hdr;
        if (app_q && (off_q == BASE)) begin
          st_d = ST_WR_NEW;
        end else if ((cur_q == BASE) && (mem_rd_data == '0)) begin
          // empty chain
          res_en  = 1'b1;
          done_d  = 1'b1;
          err_d   = app_q;
          roff_d  = '0;
          rprev_d = '0;
          st_d    = ST_IDLE;
        end else if (rd_hdr.id == srch_q) begin
          res_en  = 1'b1;
          done_d  = 1'b1;
          err_d   = app_q;
          roff_d  = app_q ? '0 : cur_q;
          rprev_d = app_q ? '0 : prev_q;
          st_d    = ST_IDLE;
        end else if (rd_hdr.nxt == '0) begin
          if (app_q) begin
            st_d = ST_WR_TAIL;
          end else begin
            res_en  = 1'b1;
            done_d  = 1'b1;
            err_d   = 1'b0;
            roff_d  = '0;
            rprev_d = cur_q;
            st_d    = ST_IDLE;
          end
        end else if (!ptr_ok || at_limit) begin
          res_en  = 1'b1;
          done_d  = 1'b1;
          err_d   = 1'b1;
          roff_d  = '0;
          rprev_d = '0;
          st_d    = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
          prev_d  = cur_q;
          cur_d   = rd_hdr.nxt;
          st_d    = ST_READ;
        end
      end

      ST_WR_TAIL: begin
        mem_wr_en   = 1'b1;
        mem_addr    = cur_q;
        mem_wr_data = {off_q, hdr_q.ver, hdr_q.id};
        st_d        = ST_WR_NEW;
      end

      ST_WR_NEW: begin
        mem_wr_en   = 1'b1;
        mem_addr    = off_q;
        mem_wr_data = {((off_q == BASE) ? hdr_q.nxt : {PTR_W{1'b0}}), ver_q, id_q};
        res_en      = 1'b1;
        done_d      = 1'b1;
        err_d       = 1'b0;
        roff_d      = off_q;
        rprev_d     = (off_q == BASE) ? '0 : cur_q;
        st_d        = ST_IDLE;
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_q  <= 1'b0;
      srch_q <= '0;
      id_q   <= '0;
      ver_q  <= '0;
      off_q  <= '0;
    end else if (ctx_en) begin
      app_q  <= app_d;
      srch_q <= srch_d;
      id_q   <= id_d;
      ver_q  <= ver_d;
      off_q  <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      hdr_q  <= '0;
    end else if (walk_en) begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      hdr_q  <= hdr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roff_q  <= '0;
      rprev_q <= '0;
      err_q   <= 1'b0;
    end else if (res_en) begin
      roff_q  <= roff_d;
      rprev_q <= rprev_d;
      err_q   <= err_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign res_offset = roff_q;
  assign res_prev   = rprev_q;
  assign res_err    = err_q;
endmodule

// File: rtl/extcap_walker_chk.sv
module extcap_walker_chk #(
  parameter int BASE_OFF = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_append,
  input logic        busy,
  input logic        done,
  input logic        res_err,
  input logic [11:0] res_offset,
  input logic [11:0] res_prev,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic [11:0] mem_addr,
  input logic [31:0] mem_wr_data
);
  localparam logic [11:0] BASE = 12'(BASE_OFF);

  assert_rd_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr >= BASE && mem_addr <= 12'hFF8 && mem_addr[1:0] == 2'b00));

  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_err) |-> (res_offset == 12'h0 && res_prev == 12'h0));

  assert_no_clash_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_find_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && !cmd_append) |=> busy);

  assert_wr_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_addr >= BASE && mem_addr[1:0] == 2'b00));

  assert_tail_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr == $past(mem_wr_data[31:20])));
endmodule

bind extcap_walker extcap_walker_chk #(.BASE_OFF(BASE_OFF)) u_walker_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_append(cmd_append),
  .busy(busy), .done(done), .res_err(res_err), .res_offset(res_offset),
  .res_prev(res_prev), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_addr(mem_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/test_extcap_walker.sv
`timescale 1ns/1ps
module test_extcap_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_append;
  logic [15:0] cmd_id;
  logic [3:0]  cmd_ver;
  logic [11:0] cmd_offset;
  logic [12:0] cmd_size;
  logic        busy, done, res_err, mem_rd_en, mem_wr_en;
  logic [11:0] res_offset, res_prev, mem_addr;
  logic [31:0] mem_wr_data, mem_rd_data;

  always #10 clk = ~clk;

  extcap_walker i_extcap_walker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_append(cmd_append),
    .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_offset(cmd_offset), .cmd_size(cmd_size),
    .busy(busy), .done(done), .res_offset(res_offset), .res_prev(res_prev),
    .res_err(res_err), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data)
  );

  // configuration memory model: read data one cycle after request
  logic [31:0] cfg_mem [0:1023];
  always @(posedge clk) begin
    if (mem_wr_en) cfg_mem[mem_addr[11:2]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= cfg_mem[mem_addr[11:2]];
  end

  typedef struct {
    logic [11:0] off;
    logic [11:0] prev;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   n_done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected results as done pulses appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected done", {res_offset, res_prev, 3'b0, res_err}, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(res_offset == e.off && res_prev == e.prev && res_err == e.err, e.tag,
              {res_offset, res_prev, 3'b0, res_err}, {e.off, e.prev, 3'b0, e.err});
      end
    end
  end

  function automatic int ix(input logic [11:0] a);
    return int'(a[11:2]);
  endfunction

  task automatic pulse_cmd(input bit app, input logic [15:0] id, input logic [3:0] ver,
                           input logic [11:0] off, input logic [12:0] size);
    cmd_valid  = 1'b1;
    cmd_append = app;
    cmd_id     = id;
    cmd_ver    = ver;
    cmd_offset = off;
    cmd_size   = size;
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic wait_done(input int start);
    int t = 0;
    while (n_done == start && t < 5000) begin
      @(posedge clk);
      t++;
    end
    @(negedge clk);
    check(done == 1'b0, "R10 done lasts one cycle", done, 0);
  endtask

  task automatic run(input bit app, input logic [15:0] id, input logic [3:0] ver,
                     input logic [11:0] off, input logic [12:0] size,
                     input logic [11:0] eoff, input logic [11:0] eprev, input logic eerr,
                     input string tag);
    exp_t e;
    int   start;
    while (busy) @(negedge clk);
    e.off = eoff; e.prev = eprev; e.err = eerr; e.tag = tag;
    sb_q.push_back(e);
    start = n_done;
    pulse_cmd(app, id, ver, off, size);
    wait_done(start);
  endtask

  task automatic mem_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    check(cfg_mem[ix(a)] == exp, tag, cfg_mem[ix(a)], exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) cfg_mem[i] = 32'h0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_append = 1'b0;
    cmd_id = '0; cmd_ver = '0; cmd_offset = '0; cmd_size = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !res_err && !mem_rd_en && !mem_wr_en, "R11 reset outputs",
          {busy, done, res_err, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 empty chain
    run(1'b0, 16'h0005, 4'h0, 12'h0, 13'h0, 12'h000, 12'h000, 1'b0, "R2 find on empty chain");

    // R7 first append at base, R8 further appends
    run(1'b1, 16'h0001, 4'h1, 12'h100, 13'h040, 12'h100, 12'h000, 1'b0, "R7 append at base");
    mem_chk(12'h100, 32'h0001_0001, "R7 base header written");
    run(1'b1, 16'h000B, 4'h2, 12'h140, 13'h010, 12'h140, 12'h100, 1'b0, "R8 append second");
    mem_chk(12'h100, 32'h1401_0001, "R8 tail next rewritten");
    mem_chk(12'h140, 32'h0002_000B, "R8 new header next zero");
    run(1'b1, 16'h0010, 4'h1, 12'h200, 13'h020, 12'h200, 12'h140, 1'b0, "R8 append third");
    mem_chk(12'h140, 32'h2002_000B, "R8 tail link to 0x200");
    mem_chk(12'h200, 32'h0001_0010, "R8 third header");

    // R3 matches, R4 misses and tail search, R1 field layout implied
    run(1'b0, 16'h000B, 4'h0, 12'h0, 13'h0, 12'h140, 12'h100, 1'b0, "R3 find middle");
    run(1'b0, 16'h0010, 4'h0, 12'h0, 13'h0, 12'h200, 12'h140, 1'b0, "R3 find last");
    run(1'b0, 16'h0001, 4'h0, 12'h0, 13'h0, 12'h100, 12'h000, 1'b0, "R3 find first R1");
    run(1'b0, 16'h0007, 4'h0, 12'h0, 13'h0, 12'h000, 12'h200, 1'b0, "R4 find absent");
    run(1'b0, 16'h0000, 4'h0, 12'h0, 13'h0, 12'h000, 12'h200, 1'b0, "R4 find tail by id 0");

    // R9 rejected appends
    run(1'b1, 16'h0030, 4'h1, 12'h300, 13'h004, 12'h000, 12'h000, 1'b1, "R9 size below 8");
    run(1'b1, 16'h0030, 4'h1, 12'hFF0, 13'h010, 12'h000, 12'h000, 1'b1, "R9 end reaches 0x1000");
    run(1'b1, 16'h0030, 4'h1, 12'h080, 13'h008, 12'h000, 12'h000, 1'b1, "R9 offset below base");
    run(1'b1, 16'h0030, 4'h1, 12'h302, 13'h008, 12'h000, 12'h000, 1'b1, "R9 misaligned offset");
    mem_chk(12'h200, 32'h0001_0010, "R9 tail untouched");
    mem_chk(12'h300, 32'h0000_0000, "R9 target untouched");

    // R5 bad pointers and the upper boundary
    cfg_mem[ix(12'h200)] = 32'h2021_0010;
    run(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 12'h000, 12'h000, 1'b1, "R5 misaligned link");
    cfg_mem[ix(12'h200)] = 32'hFFC1_0010;
    run(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 12'h000, 12'h000, 1'b1, "R5 link above 0xFF8");
    cfg_mem[ix(12'h200)] = 32'h0FC1_0010;
    run(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 12'h000, 12'h000, 1'b1, "R5 link below base");
    cfg_mem[ix(12'h200)] = 32'hFF81_0010;
    cfg_mem[ix(12'hFF8)] = 32'h0001_0077;
    run(1'b0, 16'h0077, 4'h0, 12'h0, 13'h0, 12'hFF8, 12'h200, 1'b0, "R5 link at 0xFF8 followed");
    cfg_mem[ix(12'hFF8)] = 32'h0;

    // R6 looping chain
    cfg_mem[ix(12'h200)] = 32'h1001_0010;
    run(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 12'h000, 12'h000, 1'b1, "R6 loop aborted");
    cfg_mem[ix(12'h200)] = 32'h0001_0010;

    // R7 base append on a populated chain keeps its link
    run(1'b1, 16'h0022, 4'h3, 12'h100, 13'h008, 12'h100, 12'h000, 1'b0, "R7 base append keeps link");
    mem_chk(12'h100, 32'h1403_0022, "R7 base next preserved");

    // R10 command while busy is ignored
    begin
      exp_t e;
      int   start;
      while (busy) @(negedge clk);
      e.off = 12'h200; e.prev = 12'h140; e.err = 1'b0; e.tag = "R10 in-flight find";
      sb_q.push_back(e);
      start = n_done;
      pulse_cmd(1'b0, 16'h0010, 4'h0, 12'h0, 13'h0);
      check(busy == 1'b1, "R10 busy during walk", busy, 1);
      pulse_cmd(1'b1, 16'h0055, 4'h1, 12'h400, 13'h008);
      wait_done(start);
      repeat (30) @(negedge clk);
      check(n_done == start + 1, "R10 single completion", n_done - start, 1);
      mem_chk(12'h400, 32'h0, "R10 ignored append left no header");
      mem_chk(12'h200, 32'h0001_0010, "R10 tail link unchanged");
    end

    // R9 append off base on an empty chain
    cfg_mem[ix(12'h100)] = 32'h0;
    run(1'b1, 16'h0005, 4'h1, 12'h300, 13'h008, 12'h000, 12'h000, 1'b1, "R9 append on empty chain");
    mem_chk(12'h300, 32'h0, "R9 empty chain no write");
    mem_chk(12'h100, 32'h0, "R9 empty base no write");

    check(sb_q.size() == 0, "R10 all results delivered", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule